// File: doc/BRIEF.md
# Current-Limited Frame PWM Gate Driver

This block produces the gate drive for the power switch of a switch-mode converter. A prescaler divides the system clock into base periods. A frame counter counts those base periods, and a duty value is compared against the counter to shape one pulse per frame. A single configuration word holds the base period in clocks and the frame length in base periods. The block reads that word live, so a write to it takes effect at once. The duty value is different: it is sampled only when a frame begins and is held until the frame ends.

Two feedback inputs come from comparators outside the block. The voltage-sense input holds off a new frame until the converter output has fallen below its target. The over-current input is synchronised and then latched, and it ends the pulse for the rest of the current frame. A frame-start flag tells the control software that a new frame has begun. The flag stays set until the software acknowledges it.

Top module: `smps_gate_pwm`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any edge at which `enable` was low, `pwm_out` is 0. After reset `frame_flag` is 0. `enable` low also clears the prescaler and frame counter.
- R2: `cfg_word[15:0]` is the base period B in clocks and `cfg_word[31:16]` is the frame length L in base periods. With `vsense` held low, consecutive frame starts are exactly B*L clocks apart.
- R3: The frame counter takes the values 1..L, one value per base period, starting from the frame start. `pwm_out` is high while the captured duty D is greater than or equal to the counter. This gives min(D, L)*B high clocks at the start of each frame, and D = 0 gives no high clocks.
- R4: `duty_in` is captured at frame start. A change to it during a frame has no effect until the next frame.
- R5: A change to `cfg_word` takes effect in the current frame. Reducing L to a value at or below the current count ends the frame at the next base-period tick.
- R6: Once a frame has reached L, no new frame starts while `vsense` is 1. `pwm_out` is 0 while the block waits. The first base-period tick that sees `vsense` = 0 starts a frame.
- R7: The block passes `ocp_in` through a two-stage synchroniser. A 1 on `ocp_in` drives `pwm_out` to 0 by the third clock edge. The output then stays 0 until the next frame start, even after `ocp_in` returns to 0.
- R8: Each frame start sets `frame_flag` at that edge. The flag stays at 1 until `ack` is 1 at an edge with no frame start. An `ack` at the same edge as a frame start leaves the flag at 1.
- R9: A zero in the base-period field is treated as one clock. A zero in the frame-length field is treated as one base period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run control; low clears the counters and forces the output low |
| cfg_word | input | 32 | [15:0] base period in clocks, [31:16] frame length in base periods; used live |
| duty_in | input | 16 | Duty value, captured at each frame start |
| vsense | input | 1 | Output-voltage comparator; 0 permits a new frame |
| ocp_in | input | 1 | Over-current comparator; 1 ends the pulse for the rest of the frame |
| ack | input | 1 | Clears `frame_flag` |
| pwm_out | output | 1 | Gate drive for the power switch |
| frame_flag | output | 1 | Set at each frame start, held until acknowledged |

## Verification
The bench builds the block with its default widths: 16-bit base, frame and duty fields and a two-stage synchroniser. It then drives only base periods of 0 to 3 and frame lengths of 0 to 6. With frames that short, thousands of frames fit in a single run. Zero-valued fields, duty values above the frame length, live configuration changes that cut a frame short, acknowledges that land on a frame start, and over-current pulses at every position in a frame all occur many times over. A cycle-level model of the requirements is compared against the outputs on every clock. Directed frame measurements check the clock counts from R2, R3 and R9 directly.

// File: rtl/smps_gate_pkg.sv
// Shared types for the current-limited frame PWM.
// Assumes nothing beyond the definitions below.
package smps_gate_pkg;

    // Sequencer phase: waiting for the voltage-sense input, or inside a frame
    typedef enum logic {
        SEQ_WAIT = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/smps_base_tick.sv
// Base-period prescaler. Emits one tick every max(base_len,1) clocks.
// Assumes base_len may change at any time; a new value below the running
// count ends the current period at once.
module smps_base_tick #(
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [BASE_W-1:0] base_len,
    output logic              tick
);

    logic [BASE_W-1:0] pre_cnt;
    logic [BASE_W-1:0] last_idx;

    // Index of the last clock in a base period (zero length acts as one)
    always_comb last_idx = (base_len == '0) ? '0 : base_len - 1'b1;

    assign tick = enable && (pre_cnt >= last_idx);

    // Clock counter inside the base period
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_cnt <= '0;
        else if (!enable || tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end

endmodule

// File: rtl/smps_ocp_guard.sv
// Over-current guard: synchronises the raw comparator input and latches a
// per-frame kill bit. Assumes frame_start is a one-cycle pulse from the
// sequencer; the kill bit clears at that edge and may set again afterwards.
module smps_ocp_guard #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ocp_raw,
    input  logic frame_start,
    output logic ocp_sync,
    output logic kill
);

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            // Shift the raw input through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sync_q <= '0;
                else
                    sync_q <= {sync_q[SYNC_STAGES-2:0], ocp_raw};
            end
        end else begin : g_single
            // Single-stage capture when only one flop is requested
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sync_q <= '0;
                else
                    sync_q <= ocp_raw;
            end
        end
    endgenerate

    assign ocp_sync = sync_q[SYNC_STAGES-1];

    // Per-frame kill latch: cleared by frame start or disable, set by over-current
    always_ff @(posedge clk) begin
        if (!rst_n)
            kill <= 1'b0;
        else if (!enable || frame_start)
            kill <= 1'b0;
        else if (ocp_sync)
            kill <= 1'b1;
    end

endmodule

// File: rtl/smps_frame_seq.sv
// Frame sequencer: counts base-period ticks from 1 to the frame length,
// waits for the voltage-sense input to read low before starting each new
// frame, captures the duty value at that start and keeps the frame flag.
// Assumes frame_len is live and may shrink below the running count.
module smps_frame_seq
    import smps_gate_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int DUTY_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tick,
    input  logic [FRAME_W-1:0] frame_len,
    input  logic [DUTY_W-1:0]  duty_in,
    input  logic               vsense,
    input  logic               ack,
    output logic               frame_start,
    output logic               running,
    output logic [FRAME_W-1:0] frm_cnt,
    output logic [DUTY_W-1:0]  duty_q,
    output logic               frame_flag
);

    seq_state_e         state;
    logic [FRAME_W-1:0] len_eff;
    logic               frame_done;

    // Effective frame length (zero acts as one)
    always_comb len_eff = (frame_len == '0) ? FRAME_W'(1) : frame_len;

    // A frame is finished while waiting or once the count reaches the length
    always_comb frame_done = (state == SEQ_WAIT) || (frm_cnt >= len_eff);

    assign frame_start = enable && tick && frame_done && !vsense;
    assign running     = (state == SEQ_RUN);

    // Frame counter, phase and duty capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_WAIT;
            frm_cnt <= '0;
            duty_q  <= '0;
        end else if (!enable) begin
            state   <= SEQ_WAIT;
            frm_cnt <= '0;
        end else if (tick) begin
            if (frame_start) begin
                state   <= SEQ_RUN;
                frm_cnt <= FRAME_W'(1);
                duty_q  <= duty_in;
            end else if (frame_done) begin
                state   <= SEQ_WAIT;
            end else begin
                frm_cnt <= frm_cnt + 1'b1;
            end
        end
    end

    // Frame flag: a start wins over a simultaneous acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_flag <= 1'b0;
        else
            frame_flag <= frame_start || (frame_flag && !ack);
    end

endmodule

// File: rtl/smps_gate_pwm.sv
// Current-limited frame PWM with voltage gating. Splits the configuration
// word into base period and frame length, both used live; combines the
// sequencer's count and captured duty with the over-current kill bit to form
// the gate drive. Assumes vsense and ack are synchronous to clk; ocp_in may
// be asynchronous.
module smps_gate_pwm #(
    parameter int BASE_W      = 16,
    parameter int FRAME_W     = 16,
    parameter int DUTY_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic [BASE_W+FRAME_W-1:0] cfg_word,
    input  logic [DUTY_W-1:0]         duty_in,
    input  logic                      vsense,
    input  logic                      ocp_in,
    input  logic                      ack,
    output logic                      pwm_out,
    output logic                      frame_flag
);

    localparam int CMP_W = (DUTY_W > FRAME_W) ? DUTY_W : FRAME_W;

    logic               tick;
    logic               frame_start;
    logic               running;
    logic               kill;
    logic               ocp_sync;
    logic [FRAME_W-1:0] frm_cnt;
    logic [DUTY_W-1:0]  duty_q;

    smps_base_tick #(
        .BASE_W (BASE_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .base_len (cfg_word[BASE_W-1:0]),
        .tick     (tick)
    );

    smps_frame_seq #(
        .FRAME_W (FRAME_W),
        .DUTY_W  (DUTY_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tick        (tick),
        .frame_len   (cfg_word[BASE_W+FRAME_W-1:BASE_W]),
        .duty_in     (duty_in),
        .vsense      (vsense),
        .ack         (ack),
        .frame_start (frame_start),
        .running     (running),
        .frm_cnt     (frm_cnt),
        .duty_q      (duty_q),
        .frame_flag  (frame_flag)
    );

    smps_ocp_guard #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ocp (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .ocp_raw     (ocp_in),
        .frame_start (frame_start),
        .ocp_sync    (ocp_sync),
        .kill        (kill)
    );

    // Gate drive: inside a frame, not killed, duty at or above the count
    always_comb pwm_out = running && !kill && (CMP_W'(duty_q) >= CMP_W'(frm_cnt));

endmodule

// File: rtl/smps_gate_pwm_chk.sv
// Property checker for smps_gate_pwm, attached by bind below.
// Assumes the signal names of the top module.
module smps_gate_pwm_chk #(
    parameter int DUTY_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              vsense,
    input logic              ack,
    input logic              pwm_out,
    input logic              frame_flag,
    input logic              frame_start,
    input logic              ocp_sync,
    input logic [DUTY_W-1:0] duty_q
);

    // R1
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pwm_out);

    // R3
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_out);

    // R6
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_flag) |-> $past(!vsense));

    // R7
    ocp_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_sync && !frame_start) |=> !pwm_out);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> frame_flag);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_flag && !ack) |=> frame_flag);

    // R8
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_flag && ack && !frame_start) |=> !frame_flag);

endmodule

bind smps_gate_pwm smps_gate_pwm_chk #(
    .DUTY_W (DUTY_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .vsense      (vsense),
    .ack         (ack),
    .pwm_out     (pwm_out),
    .frame_flag  (frame_flag),
    .frame_start (frame_start),
    .ocp_sync    (ocp_sync),
    .duty_q      (duty_q)
);

// File: tb/tb_smps_gate_pwm.sv
`timescale 1ns/1ps
// Bench for smps_gate_pwm: seeded random stimulus checked every clock
// against a requirement-level model, plus directed frame measurements.
module tb_smps_gate_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [31:0] cfg_word = 32'h0003_0002;
    logic [15:0] duty_in = 16'd1;
    logic        vsense = 1'b0;
    logic        ocp_in = 1'b0;
    logic        ack = 1'b1;
    logic        pwm_out;
    logic        frame_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;

    always #2 clk = ~clk;

    smps_gate_pwm dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_word   (cfg_word),
        .duty_in    (duty_in),
        .vsense     (vsense),
        .ocp_in     (ocp_in),
        .ack        (ack),
        .pwm_out    (pwm_out),
        .frame_flag (frame_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Requirement-level model state, advanced at every rising edge
    int unsigned m_pre = 0;
    logic        m_run = 0, m_kill = 0, m_s1 = 0, m_s2 = 0, m_flag = 0;
    logic [15:0] m_cnt = 0, m_duty = 0;

    function automatic logic [15:0] eff_len(input logic [15:0] v);
        return (v == 16'd0) ? 16'd1 : v;
    endfunction

    always @(posedge clk) begin : model
        logic [15:0] ml;
        logic        mt, md, ms;
        if (!rst_n) begin
            m_pre = 0; m_run = 0; m_kill = 0; m_s1 = 0; m_s2 = 0;
            m_flag = 0; m_cnt = 0; m_duty = 0;
        end else begin
            mt = enable && (m_pre + 1 >= 32'(eff_len(cfg_word[15:0])));
            ml = eff_len(cfg_word[31:16]);
            md = !m_run || (m_cnt >= ml);
            ms = enable && mt && md && !vsense;
            if (!enable || ms) m_kill = 0;
            else if (m_s2)     m_kill = 1;
            m_s2 = m_s1;
            m_s1 = ocp_in;
            m_flag = ms || (m_flag && !ack);
            if (!enable || mt) m_pre = 0; else m_pre++;
            if (!enable) begin
                m_run = 0; m_cnt = 0;
            end else if (mt) begin
                if (ms) begin m_run = 1; m_cnt = 1; m_duty = duty_in; end
                else if (md) m_run = 0;
                else m_cnt++;
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            logic e_pwm;
            e_pwm = m_run && !m_kill && (m_duty >= m_cnt);
            if (m_kill)      check(pwm_out == e_pwm, "R7", "pwm vs model", pwm_out, e_pwm);
            else if (!m_run) check(pwm_out == e_pwm, "R6", "pwm vs model", pwm_out, e_pwm);
            else             check(pwm_out == e_pwm, "R3", "pwm vs model", pwm_out, e_pwm);
            check(frame_flag == m_flag, "R8", "flag vs model", frame_flag, m_flag);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wait_flag();
        int g = 0;
        do begin @(negedge clk); g++; end while (!frame_flag && g < 2000);
    endtask

    // Measure one frame from a flag sample to the next; optionally change
    // inputs after 'mid' counted clocks
    task automatic measure(input int mid, input logic [31:0] mcfg,
                           input logic [15:0] mduty, output int clks, output int highs);
        wait_flag();
        clks = 0; highs = 0;
        do begin
            if (pwm_out) highs++;
            clks++;
            if (clks == mid) begin cfg_word = mcfg; duty_in = mduty; end
            @(negedge clk);
        end while (!frame_flag && clks < 2000);
    endtask

    task automatic setup(input logic [15:0] base, input logic [15:0] len,
                         input logic [15:0] duty);
        int c, h;
        @(negedge clk);
        cfg_word = {len, base}; duty_in = duty; vsense = 0; ocp_in = 0; ack = 1;
        measure(-1, 0, 0, c, h);
    endtask

    task automatic frame_case(input logic [15:0] base, input logic [15:0] len,
                              input logic [15:0] duty, input int e_clk,
                              input int e_hi, input string req);
        int c, h;
        setup(base, len, duty);
        measure(-1, 0, 0, c, h);
        check(c == e_clk, req, "frame clocks", c, e_clk);
        check(h == e_hi, req, "high clocks", h, e_hi);
    endtask

    task automatic rand_phase(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ($urandom % 150 == 0)
                cfg_word = {16'($urandom % 7), 16'($urandom % 4)};
            if ($urandom % 20 == 0) duty_in = 16'($urandom % 9);
            vsense = ($urandom % 4 == 0);
            ocp_in = ($urandom % 40 == 0);
            ack    = ($urandom % 3 == 0);
            if ($urandom % 1500 == 0) enable = 0;
            else if (!enable && $urandom % 8 == 0) enable = 1;
        end
        @(negedge clk);
        enable = 1; vsense = 0; ocp_in = 0; ack = 1;
    endtask

    initial begin
        int c, h;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(pwm_out == 0, "R1", "pwm after reset", pwm_out, 0);
        check(frame_flag == 0, "R1", "flag after reset", frame_flag, 0);
        cmp_en = 1;

        rand_phase(20000);

        // R2 / R3 frame period and high time
        frame_case(3, 5, 2, 15, 6, "R2");
        frame_case(3, 5, 9, 15, 15, "R3");
        frame_case(3, 5, 0, 15, 0, "R3");
        frame_case(1, 6, 4, 6, 4, "R3");
        // R9 zero fields
        frame_case(0, 4, 2, 4, 2, "R9");
        frame_case(2, 0, 1, 2, 2, "R9");

        // R4 duty change mid-frame affects only the next frame
        setup(3, 5, 2);
        measure(1, {16'd5, 16'd3}, 16'd4, c, h);
        check(h == 6, "R4", "high clocks, frame of change", h, 6);
        measure(-1, 0, 0, c, h);
        check(h == 12, "R4", "high clocks, next frame", h, 12);

        // R5 live frame-length shrink mid-frame
        setup(3, 5, 2);
        measure(4, {16'd3, 16'd3}, 16'd2, c, h);
        check(c == 9, "R5", "frame clocks after live shrink", c, 9);

        // R6 voltage gating
        setup(1, 3, 3);
        wait_flag();
        vsense = 1;
        for (int i = 0; i < 3; i++) begin
            check(pwm_out == 1, "R6", "pwm before wait", pwm_out, 1);
            @(negedge clk);
        end
        for (int i = 0; i < 20; i++) begin
            check(pwm_out == 0, "R6", "pwm while waiting", pwm_out, 0);
            check(frame_flag == 0, "R6", "no start while vsense high", frame_flag, 0);
            @(negedge clk);
        end
        vsense = 0;
        @(negedge clk);
        check(frame_flag == 1, "R6", "start after vsense low", frame_flag, 1);
        check(pwm_out == 1, "R6", "pwm at restart", pwm_out, 1);

        // R7 over-current cut-off
        setup(2, 6, 6);
        wait_flag();
        repeat (3) @(negedge clk);
        ocp_in = 1;
        @(negedge clk);
        ocp_in = 0;
        repeat (2) @(negedge clk);
        check(pwm_out == 0, "R7", "pwm low third edge after ocp", pwm_out, 0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (frame_flag) break;
            check(pwm_out == 0, "R7", "pwm stays low rest of frame", pwm_out, 0);
        end
        check(frame_flag == 1 && pwm_out == 1, "R7", "pwm high in next frame", pwm_out, 1);

        // R8 flag hold and acknowledge
        setup(2, 3, 1);
        while (frame_flag) @(negedge clk);
        ack = 0;
        wait_flag();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(frame_flag == 1, "R8", "flag held without ack", frame_flag, 1);
        end
        ack = 1;
        @(negedge clk);
        check(frame_flag == 1, "R8", "ack on start edge keeps flag", frame_flag, 1);
        ack = 0;
        @(negedge clk);
        ack = 1;
        @(negedge clk);
        check(frame_flag == 0, "R8", "ack clears flag", frame_flag, 0);

        // R1 enable low
        setup(1, 4, 4);
        enable = 0;
        @(negedge clk);
        check(pwm_out == 0, "R1", "pwm after disable", pwm_out, 0);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            check(pwm_out == 0, "R1", "pwm while disabled", pwm_out, 0);
            check(frame_flag == 0, "R1", "no frame while disabled", frame_flag, 0);
            @(negedge clk);
        end
        enable = 1;

        rand_phase(5000);
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule